// File: doc/BRIEF.md
# Windowed Thermal Trigger Controller

This block decides when dynamic thermal management should engage and when it should release. It accepts a stream of digitised on-chip temperature samples and adds them up over a fixed window of `2**WIN_LOG2` accepted samples. When the last sample of a window arrives, it forms the window average by a right shift. Because the window is long, a short thermal spike moves the average very little and is smoothed out.

Each window average is compared against a programmable trigger level. A hot average does not raise the throttle request at once. The request waits for a programmable initiation delay, and it is abandoned if a later window comes back below the trigger level before that delay runs out. An engaged request stays up until a window average falls below the trigger level less a hysteresis margin, so the output does not chatter around the threshold.

The block counts engage events and release events so that test code can check how often the trigger fires. The three configuration values are sampled only with the closing sample of each window. A change made part way through a window therefore takes effect at the window boundary.

Top module: `therm_throttle_ctrl`

## Requirements
- R1: While `rstN` is low and after its release, `throttleReq`, `windowAvg`, `activateCount` and `releaseCount` are all zero.
- R2: `windowAvg` equals the floor of the sum of the `2**WIN_LOG2` samples in a window divided by `2**WIN_LOG2`. The new value is visible after the clock edge that accepts the window's closing sample.
- R3: When a window average is greater than or equal to the trigger level and the block is idle, `throttleReq` rises after the (D+1)th rising edge that follows the edge accepting the closing sample. D is the initiation delay, and D = 0 gives the first edge. An average one below the trigger level does not engage.
- R4: Once engaged, `throttleReq` stays high between windows. It also stays high for every window average that is greater than or equal to the trigger level minus the hysteresis margin.
- R5: An engaged request falls after the first rising edge that follows the closing edge of a window whose average plus the hysteresis margin is below the trigger level.
- R6: If a window average below the trigger level arrives while an activation is pending, the activation is cancelled. In that case `throttleReq` stays low and `activateCount` is unchanged.
- R7: A window average below the trigger level while idle leaves `throttleReq` low.
- R8: `activateCount` increments by one on each rise of `throttleReq`, and `releaseCount` increments by one on each fall. Both wrap modulo `2**CNT_W`.
- R9: The trigger level, hysteresis margin and initiation delay are taken from the configuration inputs only in the cycle that accepts a window's closing sample. Values presented during the rest of the window have no effect.
- R10: Cycles with `sampleValid` low add nothing to the window and do not advance it, whatever `sampleData` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Temperature sample present this cycle |
| sampleData | input | SW | Digitised temperature sample |
| cfgTrigLevel | input | SW | Trigger level for window averages |
| cfgHystMargin | input | SW | Release margin below the trigger level |
| cfgInitDelay | input | DW | Initiation delay in cycles |
| throttleReq | output | 1 | Throttle request to the frequency/voltage controller |
| windowAvg | output | SW | Most recent window average |
| activateCount | output | CNT_W | Engage events, wrapping |
| releaseCount | output | CNT_W | Release events, wrapping |

## Verification
The window average is due one edge after the closing sample. A release is due one edge after that. An engage is due D+1 edges after the closing sample. The bench drives and samples on falling edges and counts edges from the closing sample before each check. For the engage sweep over initiation delays, it checks that the request is still low after D edges and high after D+1 edges, which pins the latency exactly. The hysteresis sweep walks the average down one step per window. The cancellation and mid-window configuration cases each look at the request and the counters at the cycle where an erroneous engage would first appear.

// File: rtl/therm_throttle_pkg.sv
package therm_throttle_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PEND   = 2'd1,
    ST_ACTIVE = 2'd2
  } thState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic loadDelay;
    logic incAct;
    logic incDeact;
  } thStrobe_t;

endpackage

// File: rtl/therm_throttle_dp.sv
module therm_throttle_dp
  import therm_throttle_pkg::*;
#(
  parameter int SW       = 10,
  parameter int WIN_LOG2 = 17,
  parameter int DW       = 16,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [SW-1:0]    sampleData,
  input  logic [SW-1:0]    cfgTrig,
  input  logic [SW-1:0]    cfgHyst,
  input  logic [DW-1:0]    cfgDelay,
  input  thStrobe_t        strb,
  output logic             avgValid,
  output logic             avgHot,
  output logic             avgCool,
  output logic             delayZero,
  output logic             delayDone,
  output logic [SW-1:0]    avgOut,
  output logic [CNT_W-1:0] actCount,
  output logic [CNT_W-1:0] deactCount
);

  localparam int ACC_W = SW + WIN_LOG2;

  logic [WIN_LOG2-1:0] sampleCnt;
  logic [ACC_W-1:0]    acc;
  logic [ACC_W-1:0]    accNext;
  logic                winClose;
  logic [SW-1:0]       trigSnap;
  logic [SW-1:0]       hystSnap;
  logic [DW-1:0]       delaySnap;
  logic [DW-1:0]       delayCnt;

  assign winClose = sampleValid && (sampleCnt == '1);
  assign accNext  = acc + ACC_W'(sampleData);

  // Window accumulation; snapshot of configuration at the window boundary.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      acc       <= '0;
      avgOut    <= '0;
      avgValid  <= 1'b0;
      trigSnap  <= '0;
      hystSnap  <= '0;
      delaySnap <= '0;
    end else begin
      avgValid <= winClose;
      if (sampleValid) begin
        sampleCnt <= sampleCnt + 1'b1;
        acc       <= winClose ? '0 : accNext;
      end
      if (winClose) begin
        avgOut    <= accNext[ACC_W-1:WIN_LOG2];
        trigSnap  <= cfgTrig;
        hystSnap  <= cfgHyst;
        delaySnap <= cfgDelay;
      end
    end
  end

  assign avgHot  = (avgOut >= trigSnap);
  assign avgCool = (({1'b0, avgOut} + {1'b0, hystSnap}) < {1'b0, trigSnap});

  // Initiation delay counter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (strb.loadDelay) begin
      delayCnt <= delaySnap;
    end else if (delayCnt != '0) begin
      delayCnt <= delayCnt - 1'b1;
    end
  end

  assign delayZero = (delaySnap == '0);
  assign delayDone = (delayCnt == DW'(1));

  // Event counters.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCount   <= '0;
      deactCount <= '0;
    end else begin
      if (strb.incAct)   actCount   <= actCount + 1'b1;
      if (strb.incDeact) deactCount <= deactCount + 1'b1;
    end
  end

  // Configuration snapshot only moves at a window boundary.
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !winClose |=> ($stable(trigSnap) && $stable(hystSnap) && $stable(delaySnap)));

  // A fresh average is flagged exactly one cycle after the closing sample.
  assert_avg_timing_R2: assert property (@(posedge clk) disable iff (!rstN)
    winClose |=> avgValid);

  // Invalid cycles leave the window state untouched.
  assert_gap_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(acc) && $stable(sampleCnt)));

endmodule

// File: rtl/therm_throttle_fsm.sv
module therm_throttle_fsm
  import therm_throttle_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      avgValid,
  input  logic      avgHot,
  input  logic      avgCool,
  input  logic      delayZero,
  input  logic      delayDone,
  output thStrobe_t strb,
  output logic      throttleReq
);

  thState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (avgValid && avgHot) begin
          if (delayZero) begin
            stateNext   = ST_ACTIVE;
            strb.incAct = 1'b1;
          end else begin
            stateNext      = ST_PEND;
            strb.loadDelay = 1'b1;
          end
        end
      end
      ST_PEND: begin
        if (avgValid && !avgHot) begin
          stateNext = ST_IDLE;
        end else if (delayDone) begin
          stateNext   = ST_ACTIVE;
          strb.incAct = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (avgValid && avgCool) begin
          stateNext     = ST_IDLE;
          strb.incDeact = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign throttleReq = (state == ST_ACTIVE);

  // A cold average while pending drops back to idle without engaging.
  assert_cancel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PEND && avgValid && !avgHot) |=> (state == ST_IDLE));

  // Between windows an engaged request holds.
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (throttleReq && !avgValid) |=> throttleReq);

  // Release happens the edge after a cool average.
  assert_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (throttleReq && avgValid && avgCool) |=> !throttleReq);

  // Idle with a cold average stays off.
  assert_idle_cold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(avgValid && avgHot)) |=> !throttleReq);

endmodule

// File: rtl/therm_throttle_ctrl.sv
module therm_throttle_ctrl
  import therm_throttle_pkg::*;
#(
  parameter int SW       = 10,
  parameter int WIN_LOG2 = 17,
  parameter int DW       = 16,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [SW-1:0]    sampleData,
  input  logic [SW-1:0]    cfgTrigLevel,
  input  logic [SW-1:0]    cfgHystMargin,
  input  logic [DW-1:0]    cfgInitDelay,
  output logic             throttleReq,
  output logic [SW-1:0]    windowAvg,
  output logic [CNT_W-1:0] activateCount,
  output logic [CNT_W-1:0] releaseCount
);

  thStrobe_t strb;
  logic avgValid, avgHot, avgCool, delayZero, delayDone;

  therm_throttle_dp #(
    .SW(SW), .WIN_LOG2(WIN_LOG2), .DW(DW), .CNT_W(CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sampleData (sampleData),
    .cfgTrig    (cfgTrigLevel),
    .cfgHyst    (cfgHystMargin),
    .cfgDelay   (cfgInitDelay),
    .strb       (strb),
    .avgValid   (avgValid),
    .avgHot     (avgHot),
    .avgCool    (avgCool),
    .delayZero  (delayZero),
    .delayDone  (delayDone),
    .avgOut     (windowAvg),
    .actCount   (activateCount),
    .deactCount (releaseCount)
  );

  therm_throttle_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .avgValid   (avgValid),
    .avgHot     (avgHot),
    .avgCool    (avgCool),
    .delayZero  (delayZero),
    .delayDone  (delayDone),
    .strb       (strb),
    .throttleReq(throttleReq)
  );

  // Each rise of the request moves the engage counter by exactly one.
  assert_act_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(throttleReq) |-> (activateCount == CNT_W'($past(activateCount) + 1'b1)));

  // Each fall of the request moves the release counter by exactly one.
  assert_rel_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(throttleReq) |-> (releaseCount == CNT_W'($past(releaseCount) + 1'b1)));

  // Counters are quiet while the request is steady.
  assert_count_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    $stable(throttleReq) |-> ($stable(activateCount) && $stable(releaseCount)));

endmodule

// File: tb/therm_throttle_ctrl_tb.sv
module therm_throttle_ctrl_tb;

  localparam int SW = 8, WL = 2, DW = 4, CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic [SW-1:0] cfgTrigLevel = '0;
  logic [SW-1:0] cfgHystMargin = '0;
  logic [DW-1:0] cfgInitDelay = '0;
  logic throttleReq;
  logic [SW-1:0] windowAvg;
  logic [CW-1:0] activateCount, releaseCount;

  int testCnt = 0, failCnt = 0;
  int expAct = 0, expRel = 0;
  bit done = 0;

  always #5 clk = ~clk;

  therm_throttle_ctrl #(.SW(SW), .WIN_LOG2(WL), .DW(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .cfgTrigLevel(cfgTrigLevel), .cfgHystMargin(cfgHystMargin),
    .cfgInitDelay(cfgInitDelay), .throttleReq(throttleReq),
    .windowAvg(windowAvg), .activateCount(activateCount),
    .releaseCount(releaseCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int v);
    sampleValid = 1'b1;
    sampleData  = SW'(v);
    @(negedge clk);
    sampleValid = 1'b0;
    sampleData  = 8'hFF;
  endtask

  task automatic win(input int a, input int b, input int c, input int d);
    push(a); push(b); push(c); push(d);
  endtask

  task automatic chkCounts(input string req);
    chk(req, int'(activateCount), expAct % 16);
    chk(req, int'(releaseCount), expRel % 16);
  endtask

  initial begin
    tick(3);
    chk("R1 req", int'(throttleReq), 0);
    chk("R1 avg", int'(windowAvg), 0);
    chkCounts("R1 counts");
    rstN = 1'b1;
    tick(1);
    chk("R1 req after release", int'(throttleReq), 0);

    cfgTrigLevel = 100; cfgHystMargin = 10; cfgInitDelay = 0;

    // R2 / R7: averaging sweep, all cold
    win(1, 2, 3, 5);
    chk("R2 floor avg", int'(windowAvg), 2);
    for (int k = 0; k < 8; k++) begin
      int a, b, c, d;
      a = k * 9; b = k * 11 + 3; c = k * 7 + 1; d = k * 12 + 2;
      win(a, b, c, d);
      chk("R2 avg sweep", int'(windowAvg), (a + b + c + d) / 4);
      tick(2);
      chk("R7 cold idle", int'(throttleReq), 0);
    end

    // R10: gaps with garbage data
    push(40); tick(2); push(41); tick(1); push(42); tick(3); push(43);
    chk("R10 gaps ignored", int'(windowAvg), (40 + 41 + 42 + 43) / 4);

    // R3 / R4 / R5: initiation delay sweep
    for (int d = 0; d < 7; d++) begin
      cfgInitDelay = DW'(d);
      win(120, 120, 120, 120);
      if (d > 0) begin
        tick(d);
        chk("R3 not before D+1", int'(throttleReq), 0);
      end
      tick(1);
      chk("R3 engage at D+1", int'(throttleReq), 1);
      expAct++;
      win(50, 50, 50, 50);
      chk("R4 held before release edge", int'(throttleReq), 1);
      tick(1);
      chk("R5 release", int'(throttleReq), 0);
      expRel++;
      chkCounts("R8 counts delay sweep");
    end

    // R3 boundary at trigger level
    cfgInitDelay = 0;
    win(99, 99, 99, 99); tick(1);
    chk("R3 one below trigger", int'(throttleReq), 0);
    win(100, 100, 100, 100); tick(1);
    chk("R3 at trigger", int'(throttleReq), 1);
    expAct++;

    // R4 / R5 hysteresis walk
    for (int v = 99; v >= 89; v--) begin
      win(v, v, v, v); tick(1);
      if (v >= 90) chk("R4 hysteresis hold", int'(throttleReq), 1);
      else         chk("R5 hysteresis release", int'(throttleReq), 0);
    end
    expRel++;
    chkCounts("R8 counts hysteresis");

    // R6 cancellation
    cfgInitDelay = 10;
    win(120, 120, 120, 120);
    win(60, 60, 60, 60);
    for (int i = 0; i < 12; i++) begin
      tick(1);
      chk("R6 cancelled stays low", int'(throttleReq), 0);
    end
    chkCounts("R6 counts unchanged");

    // R9 configuration taken at closing sample only
    cfgInitDelay = 0;
    cfgTrigLevel = 100;
    push(150); push(150); push(150);
    cfgTrigLevel = 200;
    push(150); tick(1);
    chk("R9 mid-window low trigger ignored", int'(throttleReq), 0);
    push(150); push(150); push(150);
    cfgTrigLevel = 100;
    push(150); tick(1);
    chk("R9 closing trigger applies", int'(throttleReq), 1);
    expAct++;
    win(50, 50, 50, 50); tick(1);
    chk("R9 release", int'(throttleReq), 0);
    expRel++;

    // R8 wrap
    for (int i = 0; i < 8; i++) begin
      win(130, 130, 130, 130); tick(1);
      expAct++;
      win(20, 20, 20, 20); tick(1);
      expRel++;
    end
    chkCounts("R8 wrap");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule